// File: doc/BRIEF.md
# Adjustable-Rate Time-of-Day Counter

This block keeps a running time of day as whole seconds plus nanoseconds. Internally it holds a sub-second accumulator in units of 1/256 ns. Every cycle of the timing clock it adds a programmable per-cycle increment to that accumulator. When the accumulator passes one second, it wraps and carries into the seconds counter. The current time is driven out on a parallel bus in the timing clock domain, so neighbouring logic can timestamp events.

Software works from a separate CPU clock through a small write-only register port. It fills staging registers and then writes a command word. The command can load a new time, apply a one-shot signed nanosecond offset, or load a new increment, in any combination. The command crosses to the timing domain with a toggle handshake. The `cmd_done` pin stays low until the timing domain has acted on the command and its acknowledge has come back.

Reading the time from the CPU side uses a valid/ready request channel and a valid/ready response channel. A request is accepted when `snap_req_valid` and `snap_req_ready` are both high on a CPU clock edge. The block then returns one coherent seconds/nanoseconds pair. That pair stays on `snap_sec`/`snap_ns` with `snap_valid` high until the consumer raises `snap_ready`. While a snapshot is in flight or waiting to be taken, `snap_req_ready` stays low, so a new request is back-pressured.

Register map on `wr_addr`:
- 0: seconds, low 32 bits
- 1: seconds, upper 16 bits
- 2: nanoseconds to load
- 3: signed offset in ns, two's complement
- 4: increment in 1/256 ns per cycle
- 7: command word

The command word bits are:
- bit 0: load the staged time
- bit 1: apply the offset
- bit 2: load the increment

Top module: `tod_counter`

## Requirements
- R1: After `cpu_rst_n` and `rtc_rst_n`, the outputs are in this state: `tod_sec`=0, `tod_ns`=0, `cmd_done`=1, `snap_valid`=0 and `snap_req_ready`=1. The increment is `INC_DEFAULT` (1280, i.e. 5 ns per cycle).
- R2: Each timing clock cycle, the accumulator grows by the increment. The increment has 8 fractional bits, and `tod_ns` shows the integer part of the accumulator.
- R3: When the accumulator reaches 1,000,000,000 ns (256,000,000,000 in 1/256 units), that amount is subtracted and `tod_sec` increases by one. `tod_ns` therefore never reaches 1,000,000,000.
- R4: Command bit 0 loads the staged seconds and nanoseconds and clears the fractional part. A staged nanosecond value of 1,000,000,000 or more is loaded as 999,999,999. Bit 0 takes priority over bit 1 when both are set.
- R5: Command bit 1 adds the signed offset (magnitude below 1e9 ns) on a single cycle, together with that cycle's increment. A borrow or carry goes into `tod_sec`.
- R6: Command bit 2 replaces the increment. The old increment still applies on the cycle of the load.
- R7: Asserting `rtc_rst_n` alone clears the time but keeps the programmed increment.
- R8: Writing a non-zero command word drops `cmd_done` on the next CPU edge. `cmd_done` rises again once the command has been applied. While `cmd_done` is low, writes to any register are ignored.
- R9: An accepted snapshot request returns a seconds/nanoseconds pair that the timing domain held on one cycle, somewhere between the request and the response.
- R10: While `snap_valid` is high and `snap_ready` is low, the snapshot value and `snap_valid` stay unchanged and `snap_req_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rtc_rst_n | input | 1 | Active-low time reset, clears the time only |
| cpu_clk | input | 1 | CPU register clock |
| cpu_rst_n | input | 1 | Active-low reset of the CPU side, the handshakes and the increment |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 32 | Register write data |
| cmd_done | output | 1 | High when no command is pending |
| snap_req_valid | input | 1 | Snapshot request valid |
| snap_req_ready | output | 1 | Snapshot request can be accepted |
| snap_valid | output | 1 | Snapshot response valid |
| snap_ready | input | 1 | Snapshot response accepted |
| snap_sec | output | 48 | Snapshot seconds |
| snap_ns | output | 32 | Snapshot nanoseconds |
| tod_sec | output | 48 | Running seconds, timing domain |
| tod_ns | output | 32 | Running nanoseconds, timing domain |

## Verification
The bench uses the default parameters: 48-bit seconds, 32-bit nanoseconds, 8 fractional bits, a 32-bit increment and a 5 ns default increment. With 8 fractional bits, an increment of 1000 exercises the fractional carry within a few cycles. Staging times a few hundred nanoseconds below a whole second brings the seconds carry within a short window. An increment of zero freezes the time, so every borrow and carry of an offset can be checked exactly against both the parallel bus and the snapshot channel.

// File: rtl/tod_pkg.sv
package tod_pkg;

  typedef enum logic [2:0] {
    RA_SEC_LO = 3'd0,
    RA_SEC_HI = 3'd1,
    RA_NS     = 3'd2,
    RA_OFFSET = 3'd3,
    RA_RATE   = 3'd4,
    RA_CMD    = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic load_rate;
    logic apply_offset;
    logic load_time;
  } cmd_t;

  localparam longint unsigned NS_PER_SEC = 64'd1_000_000_000;

endpackage

// File: rtl/tod_tsync.sv
module tod_tsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tog_in,
  output logic pulse
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], tog_in};
  end

  // Edge of the synchronised toggle marks one event.
  assign pulse = chain[STAGES] ^ chain[STAGES-1];
endmodule

// File: rtl/tod_cpu_regs.sv
module tod_cpu_regs
  import tod_pkg::*;
#(
  parameter int SEC_W = 48,
  parameter int NS_W  = 32,
  parameter int INC_W = 32,
  parameter logic [INC_W-1:0] INC_DEFAULT = INC_W'(1280)
) (
  input  logic             cpu_clk,
  input  logic             cpu_rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [31:0]      wr_data,
  output logic             cmd_done,
  output logic             cmd_tog,
  output cmd_t             cmd_q,
  output logic [SEC_W-1:0] set_sec,
  output logic [NS_W-1:0]  set_ns,
  output logic [31:0]      offset_ns,
  output logic [INC_W-1:0] rate_val,
  input  logic             cmd_ack_pulse,
  input  logic             snap_req_valid,
  output logic             snap_req_ready,
  output logic             snap_valid,
  input  logic             snap_ready,
  output logic [SEC_W-1:0] snap_sec,
  output logic [NS_W-1:0]  snap_ns,
  output logic             snap_tog,
  input  logic             snap_ack_pulse,
  input  logic [SEC_W-1:0] hold_sec,
  input  logic [NS_W-1:0]  hold_ns
);
  localparam int HI_W = SEC_W - 32;

  logic [31:0]   sec_lo;
  logic [HI_W-1:0] sec_hi;
  logic          wr_ok;
  logic          snap_pend;

  assign wr_ok   = wr_en && cmd_done;
  assign set_sec = {sec_hi, sec_lo};

  // Staging registers, frozen while a command is outstanding.
  always_ff @(posedge cpu_clk or negedge cpu_rst_n) begin
    if (!cpu_rst_n) begin
      sec_lo    <= '0;
      sec_hi    <= '0;
      set_ns    <= '0;
      offset_ns <= '0;
      rate_val  <= INC_DEFAULT;
    end else if (wr_ok) begin
      case (wr_addr)
        RA_SEC_LO: sec_lo    <= wr_data;
        RA_SEC_HI: sec_hi    <= wr_data[HI_W-1:0];
        RA_NS:     set_ns    <= NS_W'(wr_data);
        RA_OFFSET: offset_ns <= wr_data;
        RA_RATE:   rate_val  <= INC_W'(wr_data);
        default:   ;
      endcase
    end
  end

  // Command launch and completion tracking.
  always_ff @(posedge cpu_clk or negedge cpu_rst_n) begin
    if (!cpu_rst_n) begin
      cmd_done <= 1'b1;
      cmd_tog  <= 1'b0;
      cmd_q    <= '0;
    end else if (wr_ok && wr_addr == RA_CMD && |wr_data[2:0]) begin
      cmd_done <= 1'b0;
      cmd_tog  <= ~cmd_tog;
      cmd_q    <= cmd_t'(wr_data[2:0]);
    end else if (cmd_ack_pulse) begin
      cmd_done <= 1'b1;
    end
  end

  // Snapshot request/response channels.
  assign snap_req_ready = !snap_pend && !snap_valid;

  always_ff @(posedge cpu_clk or negedge cpu_rst_n) begin
    if (!cpu_rst_n) begin
      snap_pend  <= 1'b0;
      snap_valid <= 1'b0;
      snap_tog   <= 1'b0;
      snap_sec   <= '0;
      snap_ns    <= '0;
    end else begin
      if (snap_req_valid && snap_req_ready) begin
        snap_pend <= 1'b1;
        snap_tog  <= ~snap_tog;
      end
      if (snap_ack_pulse) begin
        snap_pend  <= 1'b0;
        snap_valid <= 1'b1;
        snap_sec   <= hold_sec;
        snap_ns    <= hold_ns;
      end else if (snap_valid && snap_ready) begin
        snap_valid <= 1'b0;
      end
    end
  end

  a_r8_stage_frozen: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    !cmd_done |=> $stable(set_sec) && $stable(set_ns) && $stable(offset_ns) && $stable(rate_val));

  a_r10_snap_held: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    snap_valid && !snap_ready |=> snap_valid && $stable(snap_sec) && $stable(snap_ns));

  a_r10_no_new_req: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    snap_valid |-> !snap_req_ready);

endmodule

// File: rtl/tod_core.sv
module tod_core
  import tod_pkg::*;
#(
  parameter int SEC_W  = 48,
  parameter int NS_W   = 32,
  parameter int FRAC_W = 8,
  parameter int INC_W  = 32,
  parameter logic [INC_W-1:0] INC_DEFAULT = INC_W'(1280)
) (
  input  logic             clk,
  input  logic             rtc_rst_n,
  input  logic             hs_rst_n,
  input  logic             cmd_pulse,
  input  cmd_t             cmd_q,
  input  logic [SEC_W-1:0] set_sec,
  input  logic [NS_W-1:0]  set_ns,
  input  logic [31:0]      offset_ns,
  input  logic [INC_W-1:0] rate_val,
  input  logic             snap_pulse,
  output logic             cmd_ack_tog,
  output logic             snap_ack_tog,
  output logic [SEC_W-1:0] hold_sec,
  output logic [NS_W-1:0]  hold_ns,
  output logic [SEC_W-1:0] tod_sec,
  output logic [NS_W-1:0]  tod_ns
);
  localparam int NSI_W = 30;
  localparam int ACC_W = NSI_W + FRAC_W;
  localparam int SUM_W = ACC_W + 3;
  localparam logic signed [SUM_W-1:0] WRAP1 = SUM_W'(NS_PER_SEC << FRAC_W);
  localparam logic signed [SUM_W-1:0] WRAP2 = SUM_W'(NS_PER_SEC << (FRAC_W + 1));
  localparam logic [NS_W-1:0] NS_LIMIT = NS_W'(NS_PER_SEC);
  localparam logic [NS_W-1:0] NS_MAX   = NS_W'(NS_PER_SEC - 64'd1);

  logic [ACC_W-1:0]        acc_q, nxt_acc, load_acc;
  logic [SEC_W-1:0]        sec_q, nxt_sec;
  logic [INC_W-1:0]        rate_q;
  logic signed [SUM_W-1:0] base, off, sum;
  logic [NS_W-1:0]         ns_clamped;
  logic                    do_load, do_offset;

  assign do_load   = cmd_pulse && cmd_q.load_time;
  assign do_offset = cmd_pulse && cmd_q.apply_offset && !cmd_q.load_time;

  assign ns_clamped = (set_ns >= NS_LIMIT) ? NS_MAX : set_ns;
  assign load_acc   = {ns_clamped[NSI_W-1:0], {FRAC_W{1'b0}}};

  // Sum of accumulator, increment and optional offset, then normalised.
  always_comb begin
    base = $signed({{(SUM_W-ACC_W){1'b0}}, acc_q}) + $signed({{(SUM_W-INC_W){1'b0}}, rate_q});
    off  = do_offset ? $signed({{(SUM_W-32){offset_ns[31]}}, offset_ns} << FRAC_W) : '0;
    sum  = base + off;
    nxt_acc = ACC_W'(sum);
    nxt_sec = sec_q;
    if (sum < 0) begin
      nxt_acc = ACC_W'(sum + WRAP1);
      nxt_sec = sec_q - SEC_W'(1);
    end else if (sum >= WRAP2) begin
      nxt_acc = ACC_W'(sum - WRAP2);
      nxt_sec = sec_q + SEC_W'(2);
    end else if (sum >= WRAP1) begin
      nxt_acc = ACC_W'(sum - WRAP1);
      nxt_sec = sec_q + SEC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rtc_rst_n) begin
    if (!rtc_rst_n) begin
      acc_q <= '0;
      sec_q <= '0;
    end else if (do_load) begin
      acc_q <= load_acc;
      sec_q <= set_sec;
    end else begin
      acc_q <= nxt_acc;
      sec_q <= nxt_sec;
    end
  end

  // Increment and handshake state live outside the time reset.
  always_ff @(posedge clk or negedge hs_rst_n) begin
    if (!hs_rst_n) begin
      rate_q       <= INC_DEFAULT;
      cmd_ack_tog  <= 1'b0;
      snap_ack_tog <= 1'b0;
      hold_sec     <= '0;
      hold_ns      <= '0;
    end else begin
      if (cmd_pulse && cmd_q.load_rate) rate_q <= rate_val;
      if (cmd_pulse) cmd_ack_tog <= ~cmd_ack_tog;
      if (snap_pulse) begin
        hold_sec     <= tod_sec;
        hold_ns      <= tod_ns;
        snap_ack_tog <= ~snap_ack_tog;
      end
    end
  end

  assign tod_sec = sec_q;
  assign tod_ns  = NS_W'(acc_q[ACC_W-1:FRAC_W]);

  a_r3_ns_below_second: assert property (@(posedge clk) disable iff (!rtc_rst_n)
    tod_ns < NS_LIMIT);

  a_r2_sec_monotonic: assert property (@(posedge clk) disable iff (!rtc_rst_n || !hs_rst_n)
    !cmd_pulse |=> tod_sec >= $past(tod_sec));

  a_r6_rate_kept: assert property (@(posedge clk) disable iff (!hs_rst_n)
    !cmd_pulse |=> $stable(rate_q));

endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter int SEC_W  = 48,
  parameter int NS_W   = 32,
  parameter int FRAC_W = 8,
  parameter int INC_W  = 32,
  parameter int SYNC_STAGES = 2,
  parameter logic [INC_W-1:0] INC_DEFAULT = INC_W'(5 << FRAC_W)
) (
  input  logic             clk,
  input  logic             rtc_rst_n,
  input  logic             cpu_clk,
  input  logic             cpu_rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [31:0]      wr_data,
  output logic             cmd_done,
  input  logic             snap_req_valid,
  output logic             snap_req_ready,
  output logic             snap_valid,
  input  logic             snap_ready,
  output logic [SEC_W-1:0] snap_sec,
  output logic [NS_W-1:0]  snap_ns,
  output logic [SEC_W-1:0] tod_sec,
  output logic [NS_W-1:0]  tod_ns
);
  logic [SYNC_STAGES-1:0] hs_rst_sync;
  logic hs_rst_n;
  logic cmd_tog, cmd_pulse, cmd_ack_tog, cmd_ack_pulse;
  logic snap_tog, snap_pulse, snap_ack_tog, snap_ack_pulse;
  cmd_t cmd_q;
  logic [SEC_W-1:0] set_sec, hold_sec;
  logic [NS_W-1:0]  set_ns, hold_ns;
  logic [31:0]      offset_ns;
  logic [INC_W-1:0] rate_val;

  // CPU-side reset, released synchronously into the timing domain.
  always_ff @(posedge clk or negedge cpu_rst_n) begin
    if (!cpu_rst_n) hs_rst_sync <= '0;
    else            hs_rst_sync <= {hs_rst_sync[SYNC_STAGES-2:0], 1'b1};
  end
  assign hs_rst_n = hs_rst_sync[SYNC_STAGES-1];

  tod_cpu_regs #(
    .SEC_W(SEC_W), .NS_W(NS_W), .INC_W(INC_W), .INC_DEFAULT(INC_DEFAULT)
  ) u_regs (
    .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmd_done(cmd_done), .cmd_tog(cmd_tog), .cmd_q(cmd_q),
    .set_sec(set_sec), .set_ns(set_ns), .offset_ns(offset_ns), .rate_val(rate_val),
    .cmd_ack_pulse(cmd_ack_pulse),
    .snap_req_valid(snap_req_valid), .snap_req_ready(snap_req_ready),
    .snap_valid(snap_valid), .snap_ready(snap_ready),
    .snap_sec(snap_sec), .snap_ns(snap_ns), .snap_tog(snap_tog),
    .snap_ack_pulse(snap_ack_pulse), .hold_sec(hold_sec), .hold_ns(hold_ns)
  );

  tod_tsync #(.STAGES(SYNC_STAGES)) u_cmd_sync (
    .clk(clk), .rst_n(hs_rst_n), .tog_in(cmd_tog), .pulse(cmd_pulse));
  tod_tsync #(.STAGES(SYNC_STAGES)) u_snap_sync (
    .clk(clk), .rst_n(hs_rst_n), .tog_in(snap_tog), .pulse(snap_pulse));
  tod_tsync #(.STAGES(SYNC_STAGES)) u_cmd_ack_sync (
    .clk(cpu_clk), .rst_n(cpu_rst_n), .tog_in(cmd_ack_tog), .pulse(cmd_ack_pulse));
  tod_tsync #(.STAGES(SYNC_STAGES)) u_snap_ack_sync (
    .clk(cpu_clk), .rst_n(cpu_rst_n), .tog_in(snap_ack_tog), .pulse(snap_ack_pulse));

  tod_core #(
    .SEC_W(SEC_W), .NS_W(NS_W), .FRAC_W(FRAC_W), .INC_W(INC_W), .INC_DEFAULT(INC_DEFAULT)
  ) u_core (
    .clk(clk), .rtc_rst_n(rtc_rst_n), .hs_rst_n(hs_rst_n),
    .cmd_pulse(cmd_pulse), .cmd_q(cmd_q),
    .set_sec(set_sec), .set_ns(set_ns), .offset_ns(offset_ns), .rate_val(rate_val),
    .snap_pulse(snap_pulse),
    .cmd_ack_tog(cmd_ack_tog), .snap_ack_tog(snap_ack_tog),
    .hold_sec(hold_sec), .hold_ns(hold_ns),
    .tod_sec(tod_sec), .tod_ns(tod_ns)
  );

endmodule

// File: tb/tb_tod_counter.sv
`timescale 1ns/1ps
module tb_tod_counter;
  localparam longint unsigned NSS = 64'd1_000_000_000;

  logic clk = 0, cpu_clk = 0;
  logic rtc_rst_n = 0, cpu_rst_n = 0;
  logic wr_en = 0;
  logic [2:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic cmd_done, snap_req_ready, snap_valid;
  logic snap_req_valid = 0, snap_ready = 0;
  logic [47:0] snap_sec, tod_sec;
  logic [31:0] snap_ns, tod_ns;

  int total = 0, passed = 0;

  always #2.5 clk = ~clk;
  always #3.5 cpu_clk = ~cpu_clk;

  tod_counter dut (
    .clk(clk), .rtc_rst_n(rtc_rst_n), .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .cmd_done(cmd_done),
    .snap_req_valid(snap_req_valid), .snap_req_ready(snap_req_ready),
    .snap_valid(snap_valid), .snap_ready(snap_ready),
    .snap_sec(snap_sec), .snap_ns(snap_ns), .tod_sec(tod_sec), .tod_ns(tod_ns)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (ok) passed++;
    else $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
  endtask

  function automatic longint unsigned to_total(input longint unsigned s, input longint unsigned n);
    return s * NSS + n;
  endfunction

  task automatic cpu_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge cpu_clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge cpu_clk); wr_en = 0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!cmd_done && n < 200) begin @(negedge cpu_clk); n++; end
    check(cmd_done == 1'b1, tag, cmd_done, 1);
  endtask

  task automatic step_check(input int cycles, input longint unsigned inc, input string tag);
    longint unsigned ps, pn, es, en;
    bit bad = 0;
    @(negedge clk); ps = tod_sec; pn = tod_ns;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      en = pn + inc; es = ps;
      if (en >= NSS) begin en -= NSS; es++; end
      if (!bad && (tod_sec != es || tod_ns != en)) begin
        bad = 1;
        $display("FAIL %s step sec actual=%0d expected=%0d ns actual=%0d expected=%0d",
                 tag, tod_sec, es, tod_ns, en);
      end
      ps = tod_sec; pn = tod_ns;
    end
    total++;
    if (!bad) passed++;
  endtask

  task automatic take_snap(output longint unsigned s, output longint unsigned n);
    int k = 0;
    while (!snap_req_ready) @(negedge cpu_clk);
    snap_req_valid = 1;
    @(negedge cpu_clk); snap_req_valid = 0;
    while (!snap_valid && k < 200) begin @(negedge cpu_clk); k++; end
    s = snap_sec; n = snap_ns;
    snap_ready = 1;
    @(negedge cpu_clk); snap_ready = 0;
  endtask

  initial begin
    #750000;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    total++;
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

  initial begin
    longint unsigned ms, mn, ss, sn, b, a;
    longint signed off;
    void'($urandom(32'd5150));
    repeat (4) @(negedge cpu_clk);
    // R1: reset values
    check(tod_sec == 0 && tod_ns == 0, "R1 time in reset", tod_ns, 0);
    check(cmd_done == 1 && snap_valid == 0 && snap_req_ready == 1, "R1 cpu flags", cmd_done, 1);
    @(negedge cpu_clk); cpu_rst_n = 1;
    @(negedge clk); rtc_rst_n = 1;
    // R1/R2: default 5 ns per cycle
    step_check(100, 5, "R1 default rate");

    // R6/R7/R2: fractional increment survives a time reset
    cpu_wr(3'd4, 32'd1000); cpu_wr(3'd7, 32'h4);
    wait_done("R6 rate load done");
    @(negedge clk); rtc_rst_n = 0;
    @(negedge clk);
    check(tod_sec == 0 && tod_ns == 0, "R7 time cleared", tod_ns, 0);
    rtc_rst_n = 1;
    begin
      longint unsigned acc = 0;
      bit bad = 0;
      for (int i = 0; i < 300; i++) begin
        if (!bad && (tod_ns != (acc >> 8) || tod_sec != 0)) begin
          bad = 1;
          $display("FAIL R7 fractional rate actual=%0d expected=%0d", tod_ns, acc >> 8);
        end
        @(negedge clk);
        acc += 1000;
      end
      check(!bad, "R2 fractional accumulate", 0, 0);
    end

    // R3/R4: random rates and start times near a second boundary
    for (int it = 0; it < 6; it++) begin
      longint unsigned inc = $urandom_range(1, 40);
      longint unsigned ns0 = NSS - inc * $urandom_range(20, 150);
      cpu_wr(3'd0, $urandom());
      cpu_wr(3'd1, {16'd0, 16'($urandom())});
      cpu_wr(3'd2, 32'(ns0));
      cpu_wr(3'd4, 32'(inc << 8));
      cpu_wr(3'd7, 32'h5);
      wait_done("R4 set done");
      step_check(300, inc, "R3 wrap into seconds");
    end

    // R4: time load with rate zero, exact values
    cpu_wr(3'd0, 32'd100); cpu_wr(3'd1, 32'd0); cpu_wr(3'd2, 32'd500);
    cpu_wr(3'd4, 32'd0); cpu_wr(3'd7, 32'h5);
    wait_done("R4 frozen set done");
    check(tod_sec == 100 && tod_ns == 500, "R4 load time", tod_ns, 500);

    // R5: directed borrow and carries
    cpu_wr(3'd3, -32'sd600); cpu_wr(3'd7, 32'h2); wait_done("R5 done");
    check(tod_sec == 99 && tod_ns == 999_999_900, "R5 borrow", tod_ns, 999_999_900);
    cpu_wr(3'd3, 32'd100); cpu_wr(3'd7, 32'h2); wait_done("R5 done");
    check(tod_sec == 100 && tod_ns == 0, "R5 carry to zero", tod_sec, 100);
    cpu_wr(3'd3, 32'd999_999_999); cpu_wr(3'd7, 32'h2); wait_done("R5 done");
    check(tod_sec == 100 && tod_ns == 999_999_999, "R5 no carry", tod_ns, 999_999_999);
    cpu_wr(3'd3, 32'd1); cpu_wr(3'd7, 32'h2); wait_done("R5 done");
    check(tod_sec == 101 && tod_ns == 0, "R5 edge carry", tod_sec, 101);

    // R5/R9: random offsets, checked on bus and snapshot
    ms = 101; mn = 0;
    for (int it = 0; it < 8; it++) begin
      longint signed t;
      off = longint'($urandom_range(0, 1_999_999_998)) - 64'sd999_999_999;
      cpu_wr(3'd3, 32'(off)); cpu_wr(3'd7, 32'h2); wait_done("R5 done");
      t = longint'(to_total(ms, mn)) + off;
      ms = longint'(t) / NSS; mn = longint'(t) % NSS;
      check(tod_sec == ms && tod_ns == mn, "R5 random offset", tod_ns, mn);
      take_snap(ss, sn);
      check(ss == ms && sn == mn, "R9 snapshot frozen", sn, mn);
    end

    // R4: priority of load over offset, clamp of large ns
    cpu_wr(3'd2, 32'd1_500_000_000); cpu_wr(3'd3, 32'd77); cpu_wr(3'd7, 32'h3);
    wait_done("R4 done");
    check(tod_sec == 100 && tod_ns == 999_999_999, "R4 clamp and priority", tod_ns, 999_999_999);

    // R8: busy writes ignored
    cpu_wr(3'd2, 32'd111); cpu_wr(3'd7, 32'h1);
    check(cmd_done == 0, "R8 done low after command", cmd_done, 0);
    cpu_wr(3'd2, 32'd222);
    wait_done("R8 done");
    check(tod_ns == 111, "R8 busy write ignored", tod_ns, 111);

    // R9: coherent snapshot while running
    cpu_wr(3'd0, 32'd1000); cpu_wr(3'd2, 32'd999_990_000);
    cpu_wr(3'd4, 32'd1792); cpu_wr(3'd7, 32'h5);
    wait_done("R9 run set");
    for (int it = 0; it < 5; it++) begin
      b = to_total(tod_sec, tod_ns);
      take_snap(ss, sn);
      a = to_total(tod_sec, tod_ns);
      check(to_total(ss, sn) >= b && to_total(ss, sn) <= a && sn < NSS,
            "R9 snapshot in window", longint'(to_total(ss, sn)), longint'(b));
    end

    // R10: response held under back-pressure
    snap_req_valid = 1;
    @(negedge cpu_clk); snap_req_valid = 0;
    while (!snap_valid) @(negedge cpu_clk);
    ss = snap_sec; sn = snap_ns;
    repeat (20) @(negedge cpu_clk);
    check(snap_valid && snap_sec == ss && snap_ns == sn, "R10 snapshot held", snap_ns, sn);
    check(snap_req_ready == 0, "R10 request blocked", snap_req_ready, 0);
    snap_ready = 1;
    @(negedge cpu_clk); snap_ready = 0;
    check(snap_valid == 0 && snap_req_ready == 1, "R10 released", snap_valid, 0);

    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end
endmodule